// File: doc/BRIEF.md
# Random Bit Handshake Port

This block is the host-facing side of a random bit source. A round generator hands it a 64-bit word through a valid/ready load interface. The block then serves the word to a host one bit at a time, least significant bit first, over three level-signalled wires: an availability flag it drives, a request line the host drives, and a data bit it drives. No host timing is assumed, and every output is a plain two-state driver.

The host waits for `avail_o`, then raises `req_i`. After a programmable presentation delay the block drops `avail_o` and shows the bit on `bit_o` in the same cycle. The host reads the bit and releases `req_i`. The bit then clears, and a recovery delay runs before `avail_o` rises again. The recovery after the last bit of a word is a separate, longer parameter, because that is when the next round is produced. If the flag has been up and no request has come, the block falls into standby after an idle timeout. A request rising edge that lands in the very cycle of that transition is lost, and the host must toggle the request to wake the block.

All delays are parameters counted in clock cycles. The request input passes through a synchronizer (two flops by default) before the state machine sees it.

Top module: `rbh_top`

## Requirements
- R1: While `rst_ni` is low, `avail_o`, `bit_o` and `standby_o` are 0 and `load_ready_o` is 1. If a word is loaded on the first edge after reset release, `avail_o` rises exactly `INIT_CYC` rising edges after that release.
- R2: `load_ready_o` is 1 exactly when all bits of the stored word have been served. A word is taken on an edge where `load_valid_i` and `load_ready_o` are both 1. Bit 0 of the word is served first, then bit 1, and so on up to bit 63.
- R3: `bit_o` is 1 only if `req_i` was 1 two edges earlier. After `req_i` falls, `bit_o` is 0 from the second rising edge onward.
- R4: When `req_i` is raised while the block is available or in standby, `avail_o` stays 1 and `bit_o` stays 0 until `PRESENT_CYC+3` rising edges have passed. On that edge `avail_o` falls and `bit_o` shows the served bit. `avail_o` and `bit_o` are never both 1.
- R5: For bits 0 to 62 of a word, `avail_o` rises `RECOV_CYC+3` rising edges after `req_i` is released.
- R6: For bit 63, `avail_o` rises `RECOV_LONG_CYC+3` rising edges after release, provided a new word was loaded during that recovery.
- R7: When the word is used up and no new word has been loaded, `avail_o` stays 0. Once a word is loaded, and recovery is over, `avail_o` rises 2 rising edges after `load_valid_i` is raised.
- R8: If `req_i` stays low, `standby_o` rises `STANDBY_CYC` rising edges after `avail_o` rises. `standby_o` is 1 only while `avail_o` is 1. Standby ends only through a request, and that request is served with the R4 latency.
- R9: `standby_o` stays 0 while a bit is held for the host, however long the request stays high.
- R10: Consider a rising edge of `req_i` that first reaches the state machine in the cycle of standby entry (`req_i` raised `STANDBY_CYC-3` edges after `avail_o` rises). That edge is ignored, and the block stays in standby with `bit_o` at 0 until `req_i` is toggled low and high again. A request raised one edge earlier is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_data_i | input | BUF_W | Next round word from the generator |
| load_valid_i | input | 1 | Round word valid |
| load_ready_o | output | 1 | Buffer empty, word can be taken |
| req_i | input | 1 | Host bit request (asynchronous level) |
| avail_o | output | 1 | A bit is ready to be requested |
| bit_o | output | 1 | Served bit, driven only during a request |
| standby_o | output | 1 | Block is in its idle standby state |

## Verification
The hardest case to reach is the lost wake-up of R10. The request edge must arrive, after the synchronizer, in exactly the one cycle where the idle timer expires. The stimulus counts edges from the observed rise of `avail_o`. From the standby timeout and the two-flop latency it picks the edge at which to raise `req_i`, so that the lost edge lands on that cycle. It also raises `req_i` one edge earlier as a contrast case, then toggles the request to show recovery from the lost wake-up. The bench serves three full words with different bit patterns. It reaches both the empty-buffer wait and the reload during the long recovery.

// File: rtl/rbh_pkg.sv
package rbh_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_WAIT,
    ST_AVAIL,
    ST_SLEEP,
    ST_PRESENT,
    ST_HOLD,
    ST_RECOVER
  } rbh_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rbh_req_sync.sv
module rbh_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sr_q[STAGES-1];
  end

  assign level_o = sr_q[STAGES-1];
  assign rise_o  = sr_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/rbh_timer.sv
module rbh_timer #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned RESET_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CNT_W'(RESET_VAL);
    else if (load_i)      cnt_q <= value_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rbh_bit_store.sv
module rbh_bit_store #(
  parameter int unsigned BUF_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUF_W-1:0] data_i,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic             pop_i,
  output logic             head_o,
  output logic             empty_o,
  output logic             last_o
);

  localparam int unsigned CW = $clog2(BUF_W + 1);

  logic [BUF_W-1:0] data_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (ready_o && valid_i) begin
      data_q <= data_i;
      cnt_q  <= CW'(BUF_W);
    end else if (pop_i && !empty_o) begin
      data_q <= data_q >> 1;
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign empty_o = (cnt_q == '0);
  assign ready_o = empty_o;
  assign last_o  = (cnt_q == CW'(1));
  assign head_o  = data_q[0];

endmodule

// File: rtl/rbh_top.sv
module rbh_top
  import rbh_pkg::*;
#(
  parameter int unsigned BUF_W          = 64,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned INIT_CYC       = 2230000,
  parameter int unsigned PRESENT_CYC    = 26500,
  parameter int unsigned RECOV_CYC      = 15500,
  parameter int unsigned RECOV_LONG_CYC = 53800,
  parameter int unsigned STANDBY_CYC    = 1500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUF_W-1:0] load_data_i,
  input  logic             load_valid_i,
  output logic             load_ready_o,
  input  logic             req_i,
  output logic             avail_o,
  output logic             bit_o,
  output logic             standby_o
);

  localparam int unsigned MAX_CYC = max_of(max_of(max_of(INIT_CYC, PRESENT_CYC),
                                                  max_of(RECOV_CYC, RECOV_LONG_CYC)),
                                           STANDBY_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] PRES_LD  = CNT_W'(PRESENT_CYC - 1);
  localparam logic [CNT_W-1:0] RCV_LD   = CNT_W'(RECOV_CYC - 1);
  localparam logic [CNT_W-1:0] RCVL_LD  = CNT_W'(RECOV_LONG_CYC - 1);
  localparam logic [CNT_W-1:0] IDLE_LD  = CNT_W'(STANDBY_CYC - 1);

  rbh_state_e       state_q, state_d;
  logic             req_lvl, req_rise;
  logic             tmr_ld, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             pop;
  logic             buf_head, buf_empty, buf_last;
  logic             bit_q, last_q;

  rbh_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (req_i),
    .level_o (req_lvl),
    .rise_o  (req_rise)
  );

  rbh_timer #(.CNT_W(CNT_W), .RESET_VAL(INIT_CYC - 1)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_ld),
    .value_i (tmr_val),
    .zero_o  (tmr_zero)
  );

  rbh_bit_store #(.BUF_W(BUF_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (load_data_i),
    .valid_i (load_valid_i),
    .ready_o (load_ready_o),
    .pop_i   (pop),
    .head_o  (buf_head),
    .empty_o (buf_empty),
    .last_o  (buf_last)
  );

  always_comb begin
    state_d = state_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    pop     = 1'b0;
    unique case (state_q)
      ST_INIT: begin
        if (tmr_zero) begin
          if (!buf_empty) begin
            state_d = ST_AVAIL;
            tmr_ld  = 1'b1;
            tmr_val = IDLE_LD;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!buf_empty) begin
          state_d = ST_AVAIL;
          tmr_ld  = 1'b1;
          tmr_val = IDLE_LD;
        end
      end
      ST_AVAIL: begin
        // timeout wins over a coincident request edge: that edge is lost
        if (tmr_zero) begin
          state_d = ST_SLEEP;
        end else if (req_rise) begin
          state_d = ST_PRESENT;
          tmr_ld  = 1'b1;
          tmr_val = PRES_LD;
        end
      end
      ST_SLEEP: begin
        if (req_rise) begin
          state_d = ST_PRESENT;
          tmr_ld  = 1'b1;
          tmr_val = PRES_LD;
        end
      end
      ST_PRESENT: begin
        if (tmr_zero) begin
          state_d = ST_HOLD;
          pop     = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!req_lvl) begin
          state_d = ST_RECOVER;
          tmr_ld  = 1'b1;
          tmr_val = last_q ? RCVL_LD : RCV_LD;
        end
      end
      ST_RECOVER: begin
        if (tmr_zero) begin
          if (!buf_empty) begin
            state_d = ST_AVAIL;
            tmr_ld  = 1'b1;
            tmr_val = IDLE_LD;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      bit_q   <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pop) begin
        bit_q  <= buf_head;
        last_q <= buf_last;
      end
    end
  end

  assign avail_o   = (state_q == ST_AVAIL) || (state_q == ST_SLEEP) || (state_q == ST_PRESENT);
  assign standby_o = (state_q == ST_SLEEP);
  assign bit_o     = (state_q == ST_HOLD) && req_lvl && bit_q;

endmodule

// File: rtl/rbh_checker.sv
module rbh_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic avail_o,
  input logic bit_o,
  input logic standby_o,
  input logic load_ready_o
);

  a_r3_bit_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> $past(req_i, 2))
    else $error("a_r3_bit_needs_req");

  a_r4_avail_bit_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o |-> !bit_o)
    else $error("a_r4_avail_bit_excl");

  a_r2_ready_not_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ready_o |-> !avail_o)
    else $error("a_r2_ready_not_avail");

  a_r8_standby_in_avail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> avail_o)
    else $error("a_r8_standby_in_avail");

  a_r8_wake_by_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(standby_o) |-> (avail_o && $past(req_i, 2)))
    else $error("a_r8_wake_by_req");

  a_r9_no_standby_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> !standby_o)
    else $error("a_r9_no_standby_bit");

endmodule

bind rbh_top rbh_checker u_rbh_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .avail_o      (avail_o),
  .bit_o        (bit_o),
  .standby_o    (standby_o),
  .load_ready_o (load_ready_o)
);

// File: tb/tb_rbh_top.sv
`timescale 1ns/1ps
module tb_rbh_top;

  localparam int W   = 64;
  localparam int INI = 10;
  localparam int PR  = 3;
  localparam int RC  = 2;
  localparam int RCL = 7;
  localparam int SB  = 6;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] load_data = '0;
  logic         load_valid = 1'b0;
  logic         load_ready;
  logic         req = 1'b0;
  logic         avail, bit_out, standby;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rbh_top #(
    .BUF_W(W), .SYNC_STAGES(2), .INIT_CYC(INI), .PRESENT_CYC(PR),
    .RECOV_CYC(RC), .RECOV_LONG_CYC(RCL), .STANDBY_CYC(SB)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_data_i(load_data), .load_valid_i(load_valid),
    .load_ready_o(load_ready), .req_i(req), .avail_o(avail), .bit_o(bit_out),
    .standby_o(standby)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one full request/release cycle; called and returning at a negedge
  task automatic serve_bit(input logic exp_bit, input bit last, input bit reload,
                           input logic [W-1:0] nxt, input int hold_n, input bit exp_rise);
    int cnt;
    int bad;
    cnt = 0; bad = 0;
    req = 1'b1;
    while (avail && cnt < 200) begin
      step();
      cnt++;
      if (bit_out !== 1'b0 && avail) bad++;
    end
    chk("R4 presentation latency", cnt, PR + 3);
    chk("R3 bit low before presentation", bad, 0);
    chk("R2 bit order / R4 bit shown", bit_out, exp_bit);
    bad = 0;
    for (int i = 0; i < hold_n; i++) begin
      step();
      if (standby !== 1'b0 || bit_out !== exp_bit) bad++;
    end
    if (hold_n > 3) chk("R9 no standby while held", bad, 0);
    req = 1'b0;
    if (reload) begin
      load_data  = nxt;
      load_valid = 1'b1;
    end
    cnt = 0; bad = 0;
    if (exp_rise) begin
      while (!avail && cnt < 200) begin
        step();
        cnt++;
        load_valid = 1'b0;
        if (cnt >= 2 && bit_out !== 1'b0) bad++;
      end
      if (last) chk("R6 long recovery", cnt, RCL + 3);
      else      chk("R5 short recovery", cnt, RC + 3);
      chk("R3 bit cleared after release", bad, 0);
    end else begin
      for (int i = 0; i < RCL + 12; i++) begin
        step();
        if (avail !== 1'b0 || (i >= 1 && bit_out !== 1'b0)) bad++;
      end
      chk("R7 avail low while empty", bad, 0);
      chk("R2 ready when empty", load_ready, 1);
    end
  endtask

  task automatic serve_word(input logic [W-1:0] w, input bit reload_next,
                            input logic [W-1:0] nxt, input bit rise_after);
    for (int i = 0; i < W; i++)
      serve_bit(w[i], i == W - 1, reload_next && i == W - 1, nxt, 1,
                (i != W - 1) || rise_after);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] wa, wb, wc;
    int cnt;
    int bad;
    wa = 64'h0123_4567_89AB_CDEF;
    wb = 64'hFFFF_0000_AAAA_5555;
    wc = wa ^ {wb[40:0], wb[63:41]};

    repeat (3) @(negedge clk);
    chk("R1 reset avail", avail, 0);
    chk("R1 reset bit", bit_out, 0);
    chk("R1 reset standby", standby, 0);
    chk("R1 reset ready", load_ready, 1);

    rst_ni = 1'b1;
    load_data = wa;
    load_valid = 1'b1;
    cnt = 0;
    while (!avail && cnt < 200) begin
      step();
      cnt++;
      load_valid = 1'b0;
    end
    chk("R1 init delay", cnt, INI);
    chk("R2 ready low after load", load_ready, 0);

    // word A, then empty wait
    serve_word(wa, 1'b0, '0, 1'b0);
    load_data = wb;
    load_valid = 1'b1;
    cnt = 0;
    while (!avail && cnt < 50) begin
      step();
      cnt++;
      load_valid = 1'b0;
    end
    chk("R7 avail after reload", cnt, 2);

    // word B with standby corner cases
    for (int i = 0; i < 10; i++) serve_bit(wb[i], 1'b0, 1'b0, '0, 1, 1'b1);
    cnt = 0;
    while (!standby && cnt < 50) begin
      step();
      cnt++;
      if (!avail) cnt = 1000;
    end
    chk("R8 standby timeout", cnt, SB);
    chk("R8 avail held in standby", avail, 1);
    serve_bit(wb[10], 1'b0, 1'b0, '0, 1, 1'b1);
    chk("R8 standby left after request", standby, 0);

    // lost wake-up: edge lands on the standby entry cycle
    repeat (SB - 3) step();
    req = 1'b1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (bit_out !== 1'b0 || avail !== 1'b1) bad++;
    end
    chk("R10 edge ignored, bit low", bad, 0);
    chk("R10 stays in standby", standby, 1);
    req = 1'b0;
    repeat (3) step();
    serve_bit(wb[11], 1'b0, 1'b0, '0, 3 * SB, 1'b1);

    // one edge earlier is served
    repeat (SB - 4) step();
    serve_bit(wb[12], 1'b0, 1'b0, '0, 1, 1'b1);
    chk("R10 early edge no standby", standby, 0);

    for (int i = 13; i < W; i++)
      serve_bit(wb[i], i == W - 1, i == W - 1, wc, (i % 7 == 0) ? 2 * SB : 1, 1'b1);
    chk("R2 ready low after preload", load_ready, 0);

    serve_word(wc, 1'b0, '0, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule